// File: doc/BRIEF.md
# Dual Timer/Counter with Gating

This block provides two independent 16-bit timer/counter channels. Each channel keeps its count as a low byte and a high byte. A channel either counts ticks from a shared clock prescaler (timer function) or counts falling edges seen on its own event pin (counter function). A run bit enables each channel. An optional gate pin can further qualify counting, so software can measure how long an external signal stays high.

One mode byte configures both channels. It selects a 13-bit, 16-bit, 8-bit auto-reload or split 8+8 arrangement for each. When a channel's count wraps, a sticky flag is set that software clears. The wrap also produces a one-cycle tick on an output that a serial port can use as its bit-rate clock. All state is reached through a byte-wide register bus with a combinational read port.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, every register reads 0x00 and no wrap tick has been produced.
- R2: Register map on `bus_addr`:
  - 0 and 1 are the low and high count bytes of channel 0.
  - 2 and 3 are the low and high count bytes of channel 1.
  - 4 is the mode byte. Channel 0 uses bits 3:0 and channel 1 uses bits 7:4. In each nibble, bit 3 is gate-enable, bit 2 selects counter function and bits 1:0 select the mode (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split).
  - 5 is the control byte. Bit 0 is run 0, bit 1 is run 1, bit 2 is fast prescale, bits 5:4 are the wrap flags of channels 1:0, and bits 7:6 are the high-half wrap flags of channels 1:0.
  - Addresses 6 and 7 read 0x00.
  - Count bytes, the mode byte and control bits 2:0 read back what was written.
- R3: In timer function with fast prescale clear, a running channel advances by exactly one per 12 clock cycles.
- R4: With fast prescale set, a running timer-function channel advances by exactly one per 4 clock cycles.
- R5: In counter function, the count advances once for each falling edge of the channel's event pin. A falling edge is a sample of 1 followed by a sample of 0 on consecutive clocks.
- R6: With gate-enable set, the channel does not count while its gate pin is low and counts while it is high.
- R7: With gate-enable clear, the gate pin has no effect on counting.
- R8: While a channel's run bit is clear, its count bytes do not change unless they are written.
- R9: In 16-bit mode, counting past 0xFFFF gives 0x0000. The wrap sets the channel's wrap flag and drives a single-cycle pulse on its `wrap_tick` bit.
- R10: In 13-bit mode, the count is the high byte joined to low-byte bits 4:0. Low-byte bits 7:5 are unchanged by counting, and a wrap from high 0xFF / low 0x1F sets the wrap flag.
- R11: In 8-bit reload mode, only the low byte counts. On its wrap it is loaded from the high byte, which is left unchanged, and the wrap flag is set.
- R12: In split mode, the low byte counts qualified events and sets the wrap flag and wrap tick on its wrap. The high byte counts prescaler ticks whenever run is set, and its wrap sets the high-half wrap flag.
- R13: Writing 1 to a flag bit of the control byte clears that flag. Writing 0 leaves it set. A wrap in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_pin | input | 2 | External event pins, one per channel |
| gate_pin | input | 2 | Gate qualification pins, one per channel |
| wrap_tick | output | 2 | One-cycle pulse per channel wrap, usable as a serial bit-rate tick |

## Verification
The embedded properties check these behaviours on every cycle:
- a stopped channel or a closed gate leaves the count bytes frozen;
- prescaler ticks and detected pin edges never occur on two consecutive cycles;
- the reload copies the high byte;
- 13-bit mode keeps the upper low-byte bits;
- a wrap tick always coincides with a set flag, and flags stay set until cleared by a write of 1.

The exact division ratios, the count of pin edges, the wrap values of each mode and the split-mode behaviour of the high half can only be shown by the bench's windows of a known length and its preset counts.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int CH_COUNT = 2;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NIB_W    = 4;

    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd5;

    // control byte bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_FAST  = 2;
    localparam int CB_FLAG  = 4;
    localparam int CB_HFLAG = 6;

    typedef enum logic [1:0] {
        MD_W13    = 2'd0,
        MD_W16    = 2'd1,
        MD_RELOAD = 2'd2,
        MD_SPLIT  = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic      gate_en;
        logic      ext_evt;
        cnt_mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_pair_t;

endpackage

// File: rtl/dtc_prescaler.sv
module dtc_prescaler #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    localparam int CNT_W = $clog2(SLOW_DIV);

    logic [CNT_W-1:0] div_d, div_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
        tick  = (div_q >= limit);
        div_d = tick ? '0 : div_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

endmodule

// File: rtl/dtc_sampler.sv
module dtc_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic gate,
    output logic fall,
    output logic gate_lvl
);
    typedef struct packed {
        logic pin_now;
        logic pin_prev;
        logic gate_now;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.pin_now  = pin;
        smp_d.pin_prev = smp_q.pin_now;
        smp_d.gate_now = gate;
        fall           = smp_q.pin_prev & ~smp_q.pin_now;
        gate_lvl       = smp_q.gate_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R5

endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
    import dtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cfg_t         cfg,
    input  logic              run,
    input  logic              gate_lvl,
    input  logic              pin_fall,
    input  logic              pre_tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              wrap,
    output logic              hi_wrap
);
    cnt_pair_t cnt_d, cnt_q;
    logic      qual, step, hi_step;

    always_comb begin
        qual    = run & (~cfg.gate_en | gate_lvl);
        step    = qual & (cfg.ext_evt ? pin_fall : pre_tick);
        hi_step = (cfg.mode == MD_SPLIT) & run & pre_tick;
        cnt_d   = cnt_q;
        wrap    = 1'b0;
        hi_wrap = 1'b0;
        unique case (cfg.mode)
            MD_W13: if (step) begin
                cnt_d.lo = {cnt_q.lo[7:5], cnt_q.lo[4:0] + 5'd1};
                if (&cnt_q.lo[4:0]) begin
                    cnt_d.hi = cnt_q.hi + 8'd1;
                    wrap     = &cnt_q.hi;
                end
            end
            MD_W16: if (step) begin
                cnt_d = cnt_q + 16'd1;
                wrap  = &cnt_q;
            end
            MD_RELOAD: if (step) begin
                if (&cnt_q.lo) begin
                    cnt_d.lo = cnt_q.hi;
                    wrap     = 1'b1;
                end else begin
                    cnt_d.lo = cnt_q.lo + 8'd1;
                end
            end
            MD_SPLIT: begin
                if (step) begin
                    cnt_d.lo = cnt_q.lo + 8'd1;
                    wrap     = &cnt_q.lo;
                end
                if (hi_step) begin
                    cnt_d.hi = cnt_q.hi + 8'd1;
                    hi_wrap  = &cnt_q.hi;
                end
            end
            default: cnt_d = cnt_q;
        endcase
        if (wr_lo) cnt_d.lo = wdata;
        if (wr_hi) cnt_d.hi = wdata;
        cnt_lo = cnt_q.lo;
        cnt_hi = cnt_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R8

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode != MD_SPLIT && cfg.gate_en && !gate_lvl && !wr_lo && !wr_hi)
        |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R6

    AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MD_RELOAD && step && (&cnt_lo) && !wr_lo)
        |=> (cnt_lo == $past(cnt_hi))); // R11

    AST_W13_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MD_W13 && !wr_lo) |=> (cnt_lo[7:5] == $past(cnt_lo[7:5]))); // R10

endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
    import dtc_pkg::*;
#(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CH_COUNT-1:0] evt_pin,
    input  logic [CH_COUNT-1:0] gate_pin,
    output logic [CH_COUNT-1:0] wrap_tick
);
    typedef struct packed {
        logic [BYTE_W-1:0]   mode;
        logic [CH_COUNT-1:0] run;
        logic                fast;
        logic [CH_COUNT-1:0] flag;
        logic [CH_COUNT-1:0] hflag;
        logic [CH_COUNT-1:0] tick;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                pre_tick;
    logic                ctrl_wr;
    logic [CH_COUNT-1:0] ch_wrap, ch_hwrap;
    logic [BYTE_W-1:0]   lo_v [CH_COUNT];
    logic [BYTE_W-1:0]   hi_v [CH_COUNT];

    assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);

    dtc_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .fast(ctl_q.fast), .tick(pre_tick)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        logic fall_w, gate_w, wlo, whi;

        assign wlo = bus_wr && (bus_addr == ADDR_W'(2 * g));
        assign whi = bus_wr && (bus_addr == ADDR_W'(2 * g + 1));

        dtc_sampler u_smp (
            .clk(clk), .rst_n(rst_n), .pin(evt_pin[g]), .gate(gate_pin[g]),
            .fall(fall_w), .gate_lvl(gate_w)
        );

        dtc_channel u_chan (
            .clk(clk), .rst_n(rst_n),
            .cfg(chan_cfg_t'(ctl_q.mode[NIB_W*g +: NIB_W])),
            .run(ctl_q.run[g]), .gate_lvl(gate_w), .pin_fall(fall_w),
            .pre_tick(pre_tick), .wr_lo(wlo), .wr_hi(whi), .wdata(bus_wdata),
            .cnt_lo(lo_v[g]), .cnt_hi(hi_v[g]),
            .wrap(ch_wrap[g]), .hi_wrap(ch_hwrap[g])
        );

        AST_TICK_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_tick[g] |-> ctl_q.flag[g]); // R9

        AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && bus_wdata[CB_FLAG + g] && !ch_wrap[g]) |=> !ctl_q.flag[g]); // R13

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q.flag[g] && !(ctrl_wr && bus_wdata[CB_FLAG + g])) |=> ctl_q.flag[g]); // R13
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.tick = ch_wrap;
        if (bus_wr && bus_addr == ADR_MODE) ctl_d.mode = bus_wdata;
        if (ctrl_wr) begin
            ctl_d.run  = bus_wdata[CB_RUN +: CH_COUNT];
            ctl_d.fast = bus_wdata[CB_FAST];
            ctl_d.flag  = ctl_q.flag  & ~bus_wdata[CB_FLAG  +: CH_COUNT];
            ctl_d.hflag = ctl_q.hflag & ~bus_wdata[CB_HFLAG +: CH_COUNT];
        end
        ctl_d.flag  = ctl_d.flag  | ch_wrap;
        ctl_d.hflag = ctl_d.hflag | ch_hwrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < CH_COUNT; i++) begin
            if (bus_addr == ADDR_W'(2 * i))     bus_rdata = lo_v[i];
            if (bus_addr == ADDR_W'(2 * i + 1)) bus_rdata = hi_v[i];
        end
        if (bus_addr == ADR_MODE) bus_rdata = ctl_q.mode;
        if (bus_addr == ADR_CTRL) bus_rdata = {ctl_q.hflag, ctl_q.flag, 1'b0,
                                               ctl_q.fast, ctl_q.run};
    end

    assign wrap_tick = ctl_q.tick;

endmodule

// File: tb/dual_timer_counter_tb_top.sv
`timescale 1ns/1ps
module dual_timer_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] evt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b11;
    logic [1:0] wrap_tick;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int tick_cnt [2] = '{0, 0};

    typedef struct {
        bit    is_tick;
        int    idx;
        int    exp;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    dual_timer_counter dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pin(evt_pin),
        .gate_pin(gate_pin), .wrap_tick(wrap_tick)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wrap_tick[0]) tick_cnt[0]++;
            if (wrap_tick[1]) tick_cnt[1]++;
        end
    end

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                int got;
                it = sb_q.pop_front();
                got = it.is_tick ? tick_cnt[it.idx] : int'(bus_rdata);
                checks++;
                if (got != it.exp) begin
                    fails++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
                end
            end
        end
    end

    // all driver tasks start and end at a falling clock edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input int exp, input string tag);
        item_t it;
        bus_addr = a;
        it.is_tick = 1'b0; it.idx = 0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_tick(input int ch, input int exp, input string tag);
        item_t it;
        it.is_tick = 1'b1; it.idx = ch; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic pulses(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            evt_pin[ch] = 1'b0;
            repeat (3) @(negedge clk);
            evt_pin[ch] = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    // window of n counting clock edges with run bits / fast from ctl
    task automatic run_pulses(input logic [7:0] ctl, input int ch, input int n);
        wr(3'd5, ctl);
        pulses(ch, n);
        repeat (3) @(negedge clk);
        wr(3'd5, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) chk(3'(a), 0, $sformatf("R1 reset addr %0d", a));
        chk_tick(0, 0, "R1 no tick ch0");

        // R2 register access
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h5A); wr(3'd3, 8'hC3);
        wr(3'd4, 8'h96); wr(3'd5, 8'h04);
        chk(3'd0, 'hA5, "R2 ch0 lo"); chk(3'd1, 'h3C, "R2 ch0 hi");
        chk(3'd2, 'h5A, "R2 ch1 lo"); chk(3'd3, 'hC3, "R2 ch1 hi");
        chk(3'd4, 'h96, "R2 mode");   chk(3'd5, 'h04, "R2 ctrl");
        chk(3'd7, 0, "R2 unused addr");
        for (int a = 0; a < 6; a++) wr(3'(a), 8'h00);

        // R3 slow timer: 120 counting edges -> 10
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h01);
        repeat (119) @(negedge clk);
        wr(3'd5, 8'h00);
        chk(3'd0, 10, "R3 slow timer lo");
        chk(3'd1, 0, "R3 slow timer hi");
        chk(3'd2, 0, "R8 ch1 stopped");

        // R4 fast timer: 40 counting edges -> 10
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h05);
        repeat (39) @(negedge clk);
        wr(3'd5, 8'h00);
        chk(3'd0, 10, "R4 fast timer lo");

        // R5 counter function
        wr(3'd0, 8'h00); wr(3'd4, 8'h05);
        run_pulses(8'h01, 0, 5);
        chk(3'd0, 5, "R5 five edges");

        // R6 gate closed, then open
        wr(3'd0, 8'h00); wr(3'd4, 8'h0D);
        gate_pin[0] = 1'b0;
        run_pulses(8'h01, 0, 3);
        chk(3'd0, 0, "R6 gate low blocks");
        gate_pin[0] = 1'b1;
        run_pulses(8'h01, 0, 3);
        chk(3'd0, 3, "R6 gate high counts");

        // R7 gate ignored when gate-enable clear
        wr(3'd0, 8'h00); wr(3'd4, 8'h05);
        gate_pin[0] = 1'b0;
        run_pulses(8'h01, 0, 2);
        chk(3'd0, 2, "R7 gate ignored");
        gate_pin[0] = 1'b1;

        // R8 run clear holds
        pulses(0, 3);
        repeat (3) @(negedge clk);
        chk(3'd0, 2, "R8 stopped counter holds");

        // R9 16-bit wrap
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
        run_pulses(8'h01, 0, 2);
        chk(3'd0, 0, "R9 wrap lo");
        chk(3'd1, 0, "R9 wrap hi");
        chk(3'd5, 'h10, "R9 flag set");
        chk_tick(0, 1, "R9 single tick");

        // R13 flag clear semantics
        wr(3'd5, 8'h00);
        chk(3'd5, 'h10, "R13 write 0 keeps flag");
        wr(3'd5, 8'h10);
        chk(3'd5, 'h00, "R13 write 1 clears flag");

        // R10 13-bit mode
        wr(3'd4, 8'h04); wr(3'd0, 8'hFF); wr(3'd1, 8'h12);
        run_pulses(8'h01, 0, 1);
        chk(3'd0, 'hE0, "R10 low carry keeps upper bits");
        chk(3'd1, 'h13, "R10 high advances");
        wr(3'd0, 8'h1F); wr(3'd1, 8'hFF);
        run_pulses(8'h01, 0, 1);
        chk(3'd0, 0, "R10 wrap lo");
        chk(3'd1, 0, "R10 wrap hi");
        chk(3'd5, 'h10, "R10 flag set");
        chk_tick(0, 2, "R10 tick");
        wr(3'd5, 8'h10);

        // R11 8-bit reload
        wr(3'd4, 8'h06); wr(3'd1, 8'hF0); wr(3'd0, 8'hFE);
        run_pulses(8'h01, 0, 2);
        chk(3'd0, 'hF0, "R11 reload lo");
        chk(3'd1, 'hF0, "R11 hi kept");
        chk(3'd5, 'h10, "R11 flag set");
        chk_tick(0, 3, "R11 tick");
        run_pulses(8'h01, 0, 1);
        chk(3'd0, 'hF1, "R11 counts on from reload");
        wr(3'd5, 8'h10);

        // R12 split mode on channel 1: 120 counting edges
        wr(3'd4, 8'h70); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd5, 8'h02);
        pulses(1, 1);
        repeat (113) @(negedge clk);
        wr(3'd5, 8'h00);
        chk(3'd2, 0, "R12 split lo wrap");
        chk(3'd3, 'h09, "R12 split hi timer");
        chk(3'd5, 'hA0, "R12 both flags");
        chk_tick(1, 1, "R12 tick from lo");
        chk(3'd0, 'hF1, "R12 ch0 untouched");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule